// File: doc/BRIEF.md
# Converter Conversion and Calibration Sequencer

This block is the digital sequencer of a serial-output sampling converter, written as synthesizable logic. It watches an acquisition line, a calibration line and its own clock, and produces a busy flag, a serial data line and a gated bit clock. A falling acquisition line commits a conversion. Once an optional guard window has passed, seventeen counted clock pulses shift out a 16-bit twos-complement word, most significant bit first. The word comes from a parallel valid/ready input rather than from analog hardware.

Raising the calibration line resets the sequencer asynchronously and aborts any conversion or calibration in progress. When the line returns low, a long calibration interval runs. During that interval the serial line carries a diagnostic pattern whenever the acquisition line is high. A status flag shows that no calibration has completed since power-up or since the last calibration request. The block can stand in for a real device when a host controller is being verified.

Back-pressure on the word input follows two rules. `res_ready` is high exactly when the sequencer is not busy. A word transfers on a rising clock edge where `res_valid` and `res_ready` are both high. A word offered while busy is not taken, and the producer must keep it valid until it is accepted.

Top module: `conv_seq`

## Requirements
- R1: While `rst_n` is low the block shows `busy`=0, `uncal`=1, `res_ready`=1, `sdata`=0 and `sclk`=0.
- R2: While idle, a conversion commits on a rising edge where `smp` is sampled low after being sampled high on the previous edge. `busy` is high from that edge on.
- R3: While `busy` is high, changes on `smp` neither start nor restart a conversion. A fall that happens during a conversion is not remembered after it.
- R4: After a commit, the next `guard_cycles` rising edges are not counted. The 17 edges after them are counted pulses, and `busy` falls on the 17th.
- R5: After counted pulse p (1 to 16), `sdata` equals bit 16−p of the converted word. `sclk` is high during the clock-high phase of counted pulses 2 to 17 and low otherwise, so a host sampling at those 16 rising `sclk` edges reads the word MSB first.
- R6: While idle after a conversion, `sdata` and `sclk` do not change until the next commit, whatever the clock does.
- R7: `res_ready` equals NOT `busy`. The converted word is the one transferred on the commit edge if there is one. Otherwise it is the last transferred word, which is 0 after reset.
- R8: `cal` high forces, without waiting for a clock edge, `busy`=1, `uncal`=1, `sdata`=0 and `sclk`=0, and aborts any work.
- R9: After `cal` falls, `busy` stays high until the 85,532nd rising edge, counted from the first edge that sees `cal` low. `busy` falls and `uncal` clears on that edge.
- R10: During the calibration count, `sdata` equals `smp` AND the parity of the number of edges counted so far. With `smp` low it is 0.
- R11: If `smp` is high at the 17th counted pulse, a fall of `smp` right after that pulse commits on the very next edge, with no extra idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; every rising edge is a potential pulse |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| cal | input | 1 | Calibration request, asynchronous reset while high |
| smp | input | 1 | Acquisition line; its fall commits a conversion |
| guard_cycles | input | 4 | Number of edges after a commit that are not counted |
| res_valid | input | 1 | Word offered on `res_data` |
| res_data | input | 16 | Twos-complement word to be shifted out |
| res_ready | output | 1 | Word input can accept (not busy) |
| busy | output | 1 | Conversion or calibration in progress |
| sdata | output | 1 | Serial result or calibration diagnostic |
| sclk | output | 1 | Bit clock, gated copy of `clk` |
| uncal | output | 1 | No calibration has completed |

## Verification
The bench targets the exact count of 17 pulses with and without a guard window. A counter that is off by one would drop `busy` a cycle early or late and shift the word by one bit. It toggles `smp` throughout a conversion to expose a design that restarts, or that queues a fall seen while busy. It raises `cal` in the middle of a conversion and again in the middle of a calibration, where a synchronous or partial reset would leave `busy` low or `sclk` running for a cycle. It also runs a back-to-back conversion on the 17th pulse, where a missed edge on `smp` would add an idle cycle. The bench checks the diagnostic parity and the full calibration length, where a wrong start edge for the count moves the fall of `busy`.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_CAL,
    ST_GUARD,
    ST_CONV
  } seq_st_e;
endpackage

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
  import conv_seq_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int CAL_CYCLES = 85532,
  parameter int GUARD_W    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cal,
  input  logic               smp,
  input  logic [GUARD_W-1:0] guard_cycles,
  output logic               busy,
  output logic               uncal,
  output logic               load,
  output logic               shift,
  output logic               win,
  output logic               in_cal,
  output logic               cal_par
);
  localparam int PW = $clog2(DATA_W + 2);
  localparam int CW = $clog2(CAL_CYCLES + 1);

  seq_st_e              st;
  logic                 smp_q;
  logic [PW-1:0]        pcnt;
  logic [GUARD_W-1:0]   gcnt;
  logic [CW-1:0]        ccnt;
  logic                 commit;

  assign commit = (st == ST_IDLE) && smp_q && !smp;

  always_ff @(posedge clk or negedge rst_n or posedge cal) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      smp_q <= 1'b0;
      pcnt  <= '0;
      gcnt  <= '0;
      ccnt  <= '0;
      uncal <= 1'b1;
    end else if (cal) begin
      st    <= ST_ARM;
      smp_q <= 1'b0;
      pcnt  <= '0;
      gcnt  <= '0;
      ccnt  <= '0;
      uncal <= 1'b1;
    end else begin
      smp_q <= smp;
      case (st)
        ST_IDLE: begin
          if (commit) begin
            pcnt <= '0;
            if (guard_cycles == '0) begin
              st <= ST_CONV;
            end else begin
              gcnt <= guard_cycles;
              st   <= ST_GUARD;
            end
          end
        end
        ST_ARM: begin
          ccnt <= CW'(1);
          st   <= ST_CAL;
        end
        ST_CAL: begin
          if (ccnt == CW'(CAL_CYCLES - 1)) begin
            st    <= ST_IDLE;
            uncal <= 1'b0;
          end else begin
            ccnt <= ccnt + CW'(1);
          end
        end
        ST_GUARD: begin
          gcnt <= gcnt - GUARD_W'(1);
          if (gcnt == GUARD_W'(1)) st <= ST_CONV;
        end
        ST_CONV: begin
          if (pcnt == PW'(DATA_W)) st <= ST_IDLE;
          else                     pcnt <= pcnt + PW'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy    = (st != ST_IDLE);
    load    = commit;
    shift   = (st == ST_CONV) && (pcnt < PW'(DATA_W));
    win     = (st == ST_CONV) && (pcnt != '0);
    in_cal  = (st == ST_CAL);
    cal_par = ccnt[0];
  end
endmodule

// File: rtl/conv_seq_ser.sv
module conv_seq_ser #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal,
  input  logic              smp,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic              ready,
  input  logic              load,
  input  logic              shift,
  input  logic              win,
  input  logic              in_cal,
  input  logic              cal_par,
  output logic              sdata,
  output logic              sclk
);
  logic [DATA_W-1:0] hold;
  logic [DATA_W-1:0] sreg;
  logic [DATA_W-1:0] word_in;
  logic              xfer;
  logic              sd_q;
  logic              win_q;

  assign xfer    = res_valid && ready;
  assign word_in = xfer ? res_data : hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold <= '0;
    else if (xfer) hold <= res_data;
  end

  always_ff @(posedge clk or negedge rst_n or posedge cal) begin
    if (!rst_n) begin
      sreg <= '0;
      sd_q <= 1'b0;
    end else if (cal) begin
      sreg <= '0;
      sd_q <= 1'b0;
    end else if (load) begin
      sreg <= word_in;
    end else if (shift) begin
      sd_q <= sreg[DATA_W-1];
      sreg <= {sreg[DATA_W-2:0], 1'b0};
    end
  end

  // window changes only while clk is low, so the gated clock is clean
  always_ff @(negedge clk or negedge rst_n or posedge cal) begin
    if (!rst_n)   win_q <= 1'b0;
    else if (cal) win_q <= 1'b0;
    else          win_q <= win;
  end

  assign sclk  = clk & win_q;
  assign sdata = in_cal ? (smp & cal_par) : sd_q;
endmodule

// File: rtl/conv_seq.sv
module conv_seq #(
  parameter int DATA_W     = 16,
  parameter int CAL_CYCLES = 85532,
  parameter int GUARD_W    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cal,
  input  logic               smp,
  input  logic [GUARD_W-1:0] guard_cycles,
  input  logic               res_valid,
  input  logic [DATA_W-1:0]  res_data,
  output logic               res_ready,
  output logic               busy,
  output logic               sdata,
  output logic               sclk,
  output logic               uncal
);
  logic load, shift, win, in_cal, cal_par;

  conv_seq_ctrl #(
    .DATA_W(DATA_W), .CAL_CYCLES(CAL_CYCLES), .GUARD_W(GUARD_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cal(cal), .smp(smp),
    .guard_cycles(guard_cycles), .busy(busy), .uncal(uncal),
    .load(load), .shift(shift), .win(win), .in_cal(in_cal),
    .cal_par(cal_par)
  );

  assign res_ready = !busy;

  conv_seq_ser #(.DATA_W(DATA_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .cal(cal), .smp(smp),
    .res_valid(res_valid), .res_data(res_data), .ready(res_ready),
    .load(load), .shift(shift), .win(win), .in_cal(in_cal),
    .cal_par(cal_par), .sdata(sdata), .sclk(sclk)
  );
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk #(
  parameter int CAL_CYCLES = 85532
) (
  input logic clk,
  input logic rst_n,
  input logic cal,
  input logic smp,
  input logic busy,
  input logic sdata,
  input logic uncal
);
  logic cal_run;
  int   cal_edges;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_run   <= 1'b0;
      cal_edges <= 0;
    end else if (cal) begin
      cal_run   <= 1'b1;
      cal_edges <= 0;
    end else if (cal_run) begin
      if (busy) cal_edges <= cal_edges + 1;
      else      cal_run   <= 1'b0;
    end
  end

  // R2
  commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n || cal)
    ($rose(busy) && !$past(cal)) |-> (!$past(smp) && $past(smp, 2)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || cal)
    (!busy && $past(!busy)) |-> $stable(sdata));

  // R8
  cal_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal |-> (busy && uncal));

  // R9
  cal_len_chk: assert property (@(posedge clk) disable iff (!rst_n || cal)
    (cal_run && !busy) |-> (cal_edges == CAL_CYCLES));

  // R9
  uncal_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uncal) |-> $fell(busy));

  // R10
  diag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || cal)
    (cal_run && busy && !smp) |-> !sdata);
endmodule

bind conv_seq conv_seq_chk #(.CAL_CYCLES(CAL_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cal(cal), .smp(smp),
  .busy(busy), .sdata(sdata), .uncal(uncal)
);

// File: tb/conv_seq_tb.sv
module conv_seq_tb;
  localparam int CAL_N = 85532;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cal = 1'b0;
  logic        smp = 1'b0;
  logic [3:0]  guard_cycles = '0;
  logic        res_valid = 1'b0;
  logic [15:0] res_data = '0;
  logic        res_ready, busy, sdata, sclk, uncal;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  conv_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cal(cal), .smp(smp),
    .guard_cycles(guard_cycles), .res_valid(res_valid),
    .res_data(res_data), .res_ready(res_ready), .busy(busy),
    .sdata(sdata), .sclk(sclk), .uncal(uncal)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #12;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // behavioural reference: mode 0 idle, 1 armed, 2 calibrating, 3 guard, 4 converting
  int          mode = 0, c = 0, g = 0, p = 0, nb = 0;
  bit          prev = 0, msd = 0, unc = 1, win_last = 0, win_exp = 0;
  bit          done_now = 0, xfer = 0, last_sd = 0, exp_sd = 0;
  logic [15:0] hold = '0, w = '0, cap = '0;
  logic [15:0] wq[$];
  bit          bq[$];

  always @(posedge clk) begin
    done_now = 0;
    if (!rst_n) begin
      mode = 0; prev = 0; hold = '0; msd = 0; unc = 1; p = 0;
      win_last = 0; win_exp = 0; wq.delete(); bq.delete();
    end else if (cal) begin
      mode = 1; prev = 0; msd = 0; unc = 1; p = 0;
      win_last = 0; win_exp = 0; wq.delete(); bq.delete(); nb = 0;
    end else begin
      xfer = res_valid && (mode == 0);
      win_exp = win_last;
      case (mode)
        0: if (prev && !smp) begin
             w = xfer ? res_data : hold;
             wq.push_back(w);
             bq.delete();
             for (int i = 15; i >= 0; i--) bq.push_back(w[i]);
             p = 0; nb = 0; cap = '0;
             if (guard_cycles == 0) mode = 4;
             else begin g = int'(guard_cycles); mode = 3; end
           end
        1: begin mode = 2; c = 1; end
        2: if (c == CAL_N - 1) begin mode = 0; unc = 0; end
           else c++;
        3: begin g--; if (g == 0) mode = 4; end
        default: begin
          p++;
          if (p <= 16) msd = bq.pop_front();
          if (p == 17) begin mode = 0; done_now = 1; end
        end
      endcase
      if (xfer) hold = res_data;
      prev = smp;
      win_last = (mode == 4) && (p > 0);
    end
    #5;
    chk(busy == (mode != 0), "R4 busy", busy, mode != 0);
    chk(res_ready == (mode == 0), "R7 ready", res_ready, mode == 0);
    chk(uncal == unc, "R9 uncal", uncal, unc);
    chk(sclk == win_exp, "R5 sclk", sclk, win_exp);
    exp_sd = (mode == 2) ? (smp & c[0]) : msd;
    chk(sdata == exp_sd, (mode == 2) ? "R10 diag" : "R5 sdata", sdata, exp_sd);
    if (sclk) begin cap = {cap[14:0], last_sd}; nb++; end
    last_sd = sdata;
    if (done_now) begin
      w = wq.pop_front();
      chk(nb == 16 && cap == w, "R5 word", cap, w);
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    run(3);
    // R1 reset state
    chk(!busy && uncal && res_ready && !sdata && !sclk, "R1 reset", {busy, uncal, res_ready, sdata, sclk}, 5'b01100);
    rst_n = 1'b1;
    tick();
    // conversion A: negative word, no guard
    res_valid = 1'b1; res_data = 16'h8001;
    tick();
    res_valid = 1'b0; smp = 1'b1;
    tick();
    smp = 1'b0;
    tick();
    chk(busy == 1'b1, "R2 commit", busy, 1);
    run(16);
    chk(busy == 1'b1, "R4 pulse16", busy, 1);
    tick();
    chk(busy == 1'b0, "R4 pulse17", busy, 0);
    run(4);
    chk(sdata == 1'b1 && sclk == 1'b0, "R6 hold", {sdata, sclk}, 2'b10);

    // conversion B: guard of 3, word offered on the commit edge, smp toggled while busy
    guard_cycles = 4'd3; smp = 1'b1;
    tick();
    res_valid = 1'b1; res_data = 16'h5A3C; smp = 1'b0;
    tick();
    chk(res_ready == 1'b0, "R7 busy ready", res_ready, 0);
    res_data = 16'hFFFF;
    smp = 1'b1; tick();
    smp = 1'b0; tick();
    smp = 1'b1; tick();
    smp = 1'b0;
    run(16);
    res_valid = 1'b0;
    chk(busy == 1'b1, "R3 no restart", busy, 1);
    tick();
    chk(busy == 1'b0, "R4 guard end", busy, 0);
    run(3);
    chk(busy == 1'b0, "R3 no queued fall", busy, 0);

    // conversion C: held word, then back-to-back re-arm on pulse 17
    guard_cycles = 4'd0; smp = 1'b1;
    tick();
    smp = 1'b0;
    tick();
    run(5);
    smp = 1'b1;
    run(12);
    chk(busy == 1'b0, "R11 end", busy, 0);
    smp = 1'b0; res_valid = 1'b1; res_data = 16'h1234;
    tick();
    res_valid = 1'b0;
    chk(busy == 1'b1, "R11 immediate", busy, 1);

    // abort conversion D with cal
    run(6);
    cal = 1'b1;
    #3;
    chk(busy && uncal && !sclk && !sdata, "R8 async", {busy, uncal, sclk, sdata}, 4'b1100);
    tick(); tick();
    cal = 1'b0;
    run(100);
    chk(busy && uncal, "R9 counting", {busy, uncal}, 2'b11);
    cal = 1'b1;
    #3;
    chk(busy == 1'b1, "R8 abort cal", busy, 1);
    tick();
    cal = 1'b0; smp = 1'b1;
    run(50);
    smp = 1'b0;
    run(CAL_N - 1 - 50);
    chk(busy == 1'b1, "R9 last busy", busy, 1);
    tick();
    chk(busy == 1'b0 && uncal == 1'b0, "R9 done", {busy, uncal}, 2'b00);

    // conversion E after calibration, guard of 1
    guard_cycles = 4'd1; res_valid = 1'b1; res_data = 16'h7FFF; smp = 1'b1;
    tick();
    res_valid = 1'b0;
    tick();
    smp = 1'b0;
    tick();
    run(17);
    chk(busy == 1'b1, "R4 guard1 pulse16", busy, 1);
    tick();
    chk(busy == 1'b0, "R4 guard1 end", busy, 0);
    run(3);
    finish_run();
  end
endmodule